// File: doc/BRIEF.md
# Control Register Bank with Bit-Set/Bit-Clear Aliases and Soft-Reset Sequencer

This block is the control register bank of a display controller. Every register occupies a 16-byte slot that has several write addresses: a plain write, an alias that ORs the written data into the register, and an alias that clears the bits that are set in the written data. A fourth address in the slot reads the register but ignores writes. All addresses of a slot read the same value, so software can poll through any of them.

Register 0 is the control register. Its top bit is the module soft-reset bit and the bit below it is the clock-gate bit. Bit 0 is the engine run bit. A reset sequencer state machine owns the two top bits. Setting soft reset holds the rest of the controller in reset, clears its FIFOs and gates its clock. Clearing either bit takes effect only after a programmable settling time, and software polls the bit until it reads 0. The run bit is owned by a second state machine. When the run bit is cleared, the engine keeps going for a programmable drain time, and the bit reads 1 until that time has passed. Registers 1 to NUM_REGS-1 are plain configuration registers that drive the `cfg_o` bus.

Reset sequencer states: HELD (soft reset and gate both 1), RELEASING (soft reset still reads 1 while the settle count runs), GATED (soft reset 0, gate 1), UNGATING (gate still reads 1 while the settle count runs) and LIVE (both 0). Its transitions are as follows. Writing 1 to soft reset moves any state to HELD. HELD goes to RELEASING when soft reset is written 0. RELEASING goes to GATED when its count expires. GATED goes to UNGATING when gate is written 0. UNGATING goes to LIVE when its count expires, and back to GATED when gate is written 1. LIVE goes to GATED when gate is written 1.

Run states: IDLE, ACTIVE and DRAINING. IDLE goes to ACTIVE when run is written 1 and reset is not held. ACTIVE goes to DRAINING when run is written 0. DRAINING goes back to ACTIVE when run is written 1, and to IDLE when its count expires. While soft reset is held, or is being written 1, any run state goes to IDLE.

Top module: `srb_ctrl_bank`

## Requirements
- R1: Register r uses byte addresses r*16 + 4*k. Address bits [3:2] select the access kind: 0 is a plain write, 1 is the set alias, 2 is the clear alias and 3 is read-only. A plain write stores the data. `rdata_o` shows the addressed register combinationally, and it is the same for all four values of bits [3:2].
- R2: A write to the set alias (offset 0x4) makes the register equal to its old value OR the write data.
- R3: A write to the clear alias (offset 0x8) makes the register equal to its old value AND NOT the write data.
- R4: Writes are applied one per clock in bus order, so the later of two writes to the same bit wins. A write at offset 0xC changes nothing. A slot index of NUM_REGS or more ignores writes and reads 0.
- R5: Writing 1 to control bit 31 (soft reset) sets bits 31 and 30 from the next cycle. While bit 31 reads 1, `rst_hold_o` and `fifo_clr_o` are 1 and `clk_gate_o` is 1.
- R6: After soft reset is written 0 from HELD, bit 31 reads 1 for SETTLE_CYC cycles and then 0. Bit 30 stays 1.
- R7: When bit 31 reads 0, writing 0 to bit 30 (clock gate) leaves it reading 1 for SETTLE_CYC cycles and then 0, and `clk_gate_o` follows it. A write of 0 to bit 30 while in HELD is ignored.
- R8: Writing 1 to control bit 0 (run) makes `run_o` and bit 0 read 1 from the next cycle. This write is ignored while soft reset is held.
- R9: Writing 0 to the run bit keeps it and `run_o` at 1 for DRAIN_CYC cycles, then both go to 0. Writing 1 to the run bit during that time keeps it running.
- R10: Writing 1 to soft reset clears the run bit and `run_o` from the next cycle, with no drain.
- R11: After reset, control register 0 reads 0xC000_0000 and every configuration register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address (slot index in bits above 3, access kind in bits [3:2]) |
| wdata_i | input | DATA_W | Write data |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rdata_o | output | DATA_W | Read data of the addressed register |
| rst_hold_o | output | 1 | Holds the rest of the controller in reset |
| fifo_clr_o | output | 1 | Clears the controller FIFOs |
| clk_gate_o | output | 1 | Requests the controller clock to be gated |
| run_o | output | 1 | Engine running (includes drain time) |
| cfg_o | output | (NUM_REGS-1)*DATA_W | Contents of configuration registers 1..NUM_REGS-1 |

## Verification
The bench builds the bank with NUM_REGS=4, SETTLE_CYC=3, DRAIN_CYC=2 and an 8-bit address. With four registers, every alias address of every slot can be swept, and the slot indices above the last register are unused addresses that are also reachable. The short settle and drain counts let the bench check, cycle by cycle, the exact edge at which soft reset, clock gate and run fall. The bench drives the full sequence through all five sequencer states, and it also covers the drain being restarted part way through and soft reset cutting off a running engine.

// File: rtl/srb_pkg.sv
package srb_pkg;

    // Access kind decoded from address bits [3:2]
    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_RO    = 2'd3
    } op_e;

    // Reset / clock-gate sequencer states
    typedef enum logic [2:0] {
        RS_HELD      = 3'd0,
        RS_RELEASING = 3'd1,
        RS_GATED     = 3'd2,
        RS_UNGATING  = 3'd3,
        RS_LIVE      = 3'd4
    } rst_state_e;

    // Engine run states
    typedef enum logic [1:0] {
        RN_IDLE     = 2'd0,
        RN_ACTIVE   = 2'd1,
        RN_DRAINING = 2'd2
    } run_state_e;

    localparam int SLOT_LSB = 4;

endpackage

// File: rtl/srb_alias_decode.sv
module srb_alias_decode
    import srb_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = ADDR_W - SLOT_LSB
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    output logic [IDX_W-1:0]  idx_o,
    output op_e               op_o,
    output logic              hit_o,
    output logic              wr_ok_o
);

    always_comb begin
        idx_o   = addr_i[ADDR_W-1:SLOT_LSB];
        op_o    = op_e'(addr_i[3:2]);
        hit_o   = (32'(idx_o) < NUM_REGS);
        wr_ok_o = wr_en_i && hit_o;
    end

endmodule

// File: rtl/srb_merge.sv
module srb_merge
    import srb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              en_i,
    input  op_e               op_i,
    input  logic [DATA_W-1:0] cur_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] wr1_o,
    output logic [DATA_W-1:0] wr0_o,
    output logic [DATA_W-1:0] nxt_o
);

    // wr1: bits this write drives to 1; wr0: bits it drives to 0
    always_comb begin
        wr1_o = '0;
        wr0_o = '0;
        if (en_i) begin
            unique case (op_i)
                OP_PLAIN: begin
                    wr1_o = wdata_i;
                    wr0_o = ~wdata_i;
                end
                OP_SET: wr1_o = wdata_i;
                OP_CLR: wr0_o = wdata_i;
                OP_RO:  ;
            endcase
        end
        nxt_o = (cur_i & ~wr0_o) | wr1_o;
    end

endmodule

// File: rtl/srb_reset_seq.sv
module srb_reset_seq
    import srb_pkg::*;
#(
    parameter int SETTLE_CYC = 16,
    localparam int CNT_W     = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic srst_wr1_i,
    input  logic srst_wr0_i,
    input  logic gate_wr1_i,
    input  logic gate_wr0_i,
    output logic srst_bit_o,
    output logic gate_bit_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);

    rst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (srst_wr1_i) begin
            state_d = RS_HELD;
        end else begin
            unique case (state_q)
                RS_HELD: begin
                    if (srst_wr0_i) begin
                        state_d = RS_RELEASING;
                        cnt_d   = CNT_LOAD;
                    end
                end
                RS_RELEASING: begin
                    if (cnt_q == '0) state_d = RS_GATED;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                RS_GATED: begin
                    if (gate_wr0_i) begin
                        state_d = RS_UNGATING;
                        cnt_d   = CNT_LOAD;
                    end
                end
                RS_UNGATING: begin
                    if (gate_wr1_i)          state_d = RS_GATED;
                    else if (cnt_q == '0)    state_d = RS_LIVE;
                    else                     cnt_d   = cnt_q - 1'b1;
                end
                RS_LIVE: begin
                    if (gate_wr1_i) state_d = RS_GATED;
                end
                default: state_d = RS_HELD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RS_HELD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        srst_bit_o = 1'b0;
        gate_bit_o = 1'b1;
        unique case (state_q)
            RS_HELD, RS_RELEASING: srst_bit_o = 1'b1;
            RS_GATED, RS_UNGATING: srst_bit_o = 1'b0;
            RS_LIVE:               gate_bit_o = 1'b0;
            default:               srst_bit_o = 1'b1;
        endcase
    end

    p_enter_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_wr1_i |=> (state_q == RS_HELD));

    p_srst_fall_after_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(srst_bit_o) |-> ($past(state_q) == RS_RELEASING && $past(cnt_q) == '0));

    p_gate_fall_after_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(gate_bit_o) |-> ($past(state_q) == RS_UNGATING && $past(cnt_q) == '0));

    p_gate_kept_in_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RS_HELD && !srst_wr0_i) |=> (gate_bit_o && srst_bit_o));

endmodule

// File: rtl/srb_run_ctl.sv
module srb_run_ctl
    import srb_pkg::*;
#(
    parameter int DRAIN_CYC = 8,
    localparam int CNT_W    = (DRAIN_CYC < 2) ? 1 : $clog2(DRAIN_CYC)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_wr1_i,
    input  logic run_wr0_i,
    input  logic force_off_i,
    output logic run_bit_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DRAIN_CYC - 1);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (force_off_i) begin
            state_d = RN_IDLE;
        end else begin
            unique case (state_q)
                RN_IDLE: begin
                    if (run_wr1_i) state_d = RN_ACTIVE;
                end
                RN_ACTIVE: begin
                    if (run_wr0_i) begin
                        state_d = RN_DRAINING;
                        cnt_d   = CNT_LOAD;
                    end
                end
                RN_DRAINING: begin
                    if (run_wr1_i)        state_d = RN_ACTIVE;
                    else if (cnt_q == '0) state_d = RN_IDLE;
                    else                  cnt_d   = cnt_q - 1'b1;
                end
                default: state_d = RN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RN_ACTIVE, RN_DRAINING: run_bit_o = 1'b1;
            default:                run_bit_o = 1'b0;
        endcase
    end

    p_force_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_off_i |=> !run_bit_o);

    p_no_start_when_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_bit_o) |-> !$past(force_off_i));

    p_drain_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RN_ACTIVE && run_wr0_i && !force_off_i) |=> (state_q == RN_DRAINING && run_bit_o));

endmodule

// File: rtl/srb_ctrl_bank.sv
module srb_ctrl_bank
    import srb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int NUM_REGS   = 4,
    parameter int SETTLE_CYC = 16,
    parameter int DRAIN_CYC  = 8
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic                           wr_en_i,
    output logic [DATA_W-1:0]              rdata_o,
    output logic                           rst_hold_o,
    output logic                           fifo_clr_o,
    output logic                           clk_gate_o,
    output logic                           run_o,
    output logic [(NUM_REGS-1)*DATA_W-1:0] cfg_o
);

    localparam int IDX_W    = ADDR_W - SLOT_LSB;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int SRST_BIT = DATA_W - 1;
    localparam int GATE_BIT = DATA_W - 2;
    localparam int RUN_BIT  = 0;
    localparam int MISC_W   = DATA_W - 3;

    logic [IDX_W-1:0] idx;
    op_e              op;
    logic             hit, wr_ok;

    srb_alias_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .addr_i (addr_i),
        .wr_en_i(wr_en_i),
        .idx_o  (idx),
        .op_o   (op),
        .hit_o  (hit),
        .wr_ok_o(wr_ok)
    );

    // Control register 0
    logic              srst_bit, gate_bit, run_bit;
    logic [MISC_W-1:0] misc_q;
    logic [DATA_W-1:0] ctrl_cur, ctrl_wr1, ctrl_wr0, ctrl_nxt;
    logic              ctrl_sel;

    assign ctrl_cur = {srst_bit, gate_bit, misc_q, run_bit};
    assign ctrl_sel = wr_ok && (idx == '0);

    srb_merge #(.DATA_W(DATA_W)) u_ctrl_merge (
        .en_i   (ctrl_sel),
        .op_i   (op),
        .cur_i  (ctrl_cur),
        .wdata_i(wdata_i),
        .wr1_o  (ctrl_wr1),
        .wr0_o  (ctrl_wr0),
        .nxt_o  (ctrl_nxt)
    );

    srb_reset_seq #(.SETTLE_CYC(SETTLE_CYC)) u_rseq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .srst_wr1_i(ctrl_wr1[SRST_BIT]),
        .srst_wr0_i(ctrl_wr0[SRST_BIT]),
        .gate_wr1_i(ctrl_wr1[GATE_BIT]),
        .gate_wr0_i(ctrl_wr0[GATE_BIT]),
        .srst_bit_o(srst_bit),
        .gate_bit_o(gate_bit)
    );

    logic force_off;
    assign force_off = srst_bit || ctrl_wr1[SRST_BIT];

    srb_run_ctl #(.DRAIN_CYC(DRAIN_CYC)) u_run (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_wr1_i  (ctrl_wr1[RUN_BIT]),
        .run_wr0_i  (ctrl_wr0[RUN_BIT]),
        .force_off_i(force_off),
        .run_bit_o  (run_bit)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       misc_q <= '0;
        else if (ctrl_sel) misc_q <= ctrl_nxt[GATE_BIT-1:RUN_BIT+1];
    end

    // Configuration registers
    logic [DATA_W-1:0] reg_view [NUM_REGS];
    assign reg_view[0] = ctrl_cur;

    for (genvar r = 1; r < NUM_REGS; r++) begin : g_cfg
        logic [DATA_W-1:0] q, nxt, wr1, wr0;
        logic              sel;

        assign sel = wr_ok && (idx == IDX_W'(r));

        srb_merge #(.DATA_W(DATA_W)) u_merge (
            .en_i   (sel),
            .op_i   (op),
            .cur_i  (q),
            .wdata_i(wdata_i),
            .wr1_o  (wr1),
            .wr0_o  (wr0),
            .nxt_o  (nxt)
        );

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)  q <= '0;
            else if (sel) q <= nxt;
        end

        assign reg_view[r]                    = q;
        assign cfg_o[(r-1)*DATA_W +: DATA_W]  = q;
    end

    // Readback and controller-side outputs
    assign rdata_o    = hit ? reg_view[idx[SEL_W-1:0]] : '0;
    assign rst_hold_o = srst_bit;
    assign fifo_clr_o = srst_bit;
    assign clk_gate_o = gate_bit;
    assign run_o      = run_bit;

    p_set_alias_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && hit && idx == IDX_W'(1) && op == OP_SET)
        |=> reg_view[1] == ($past(reg_view[1]) | $past(wdata_i)));

    p_clr_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && hit && idx == IDX_W'(1) && op == OP_CLR)
        |=> reg_view[1] == ($past(reg_view[1]) & ~$past(wdata_i)));

    p_ro_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && op == OP_RO) |=> $stable(reg_view[1]));

    p_hold_gates_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_hold_o |-> (clk_gate_o && fifo_clr_o && !run_o));

endmodule

// File: tb/srb_ctrl_bank_test.sv
module srb_ctrl_bank_test;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NR = 4;
    localparam int ST = 3;
    localparam int DR = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic              wr_en = 1'b0;
    logic [DW-1:0]     rdata;
    logic              hold, fclr, gate, run;
    logic [(NR-1)*DW-1:0] cfg;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    srb_ctrl_bank #(.ADDR_W(AW), .DATA_W(DW), .NUM_REGS(NR),
                    .SETTLE_CYC(ST), .DRAIN_CYC(DR)) uut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rdata_o(rdata), .rst_hold_o(hold),
        .fifo_clr_o(fclr), .clk_gate_o(gate), .run_o(run), .cfg_o(cfg)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] model [NR];
        logic [DW-1:0] ctrl_exp;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(8'h00, v); chk("R11 ctrl reset", v, 32'hC000_0000);
        for (int r = 1; r < NR; r++) begin
            rd(AW'(r*16), v); chk("R11 cfg reset", v, 32'h0);
            model[r] = '0;
        end
        chk("R5 hold at reset", {31'b0, hold}, 32'd1);
        chk("R5 fifo clear at reset", {31'b0, fclr}, 32'd1);
        chk("R5 gate at reset", {31'b0, gate}, 32'd1);

        // R8 run ignored while held
        wr(8'h04, 32'h1);
        chk("R8 run blocked in reset", {31'b0, run}, 32'd0);
        rd(8'h00, v); chk("R8 run bit blocked", v, 32'hC000_0000);

        // R7 gate clear ignored while held
        wr(8'h08, 32'h4000_0000);
        rd(8'h0C, v); chk("R7 gate clear ignored in reset", v, 32'hC000_0000);

        // R6 release timeline
        wr(8'h08, 32'h8000_0000);
        for (int k = 0; k <= ST; k++) begin
            rd(AW'(k % 4 * 4), v);
            chk("R6 srst settle", {31'b0, v[31]}, (k < ST) ? 32'd1 : 32'd0);
            chk("R6 gate stays", {31'b0, v[30]}, 32'd1);
            chk("R5 hold follows srst", {31'b0, hold}, (k < ST) ? 32'd1 : 32'd0);
            if (k < ST) tick();
        end

        // R7 ungate timeline
        wr(8'h08, 32'h4000_0000);
        for (int k = 0; k <= ST; k++) begin
            chk("R7 gate settle", {31'b0, gate}, (k < ST) ? 32'd1 : 32'd0);
            rd(8'h04, v);
            chk("R7 gate readback", {31'b0, v[30]}, (k < ST) ? 32'd1 : 32'd0);
            if (k < ST) tick();
        end
        wr(8'h08, 32'h8000_0000);
        rd(8'h00, v); chk("R6 second srst clear no-op", v, 32'h0);

        // R8 start
        wr(8'h04, 32'h1);
        chk("R8 run starts", {31'b0, run}, 32'd1);
        rd(8'h00, v); chk("R8 run bit", v, 32'h1);

        // R9 drain
        wr(8'h08, 32'h1);
        for (int k = 0; k <= DR; k++) begin
            chk("R9 drain run_o", {31'b0, run}, (k < DR) ? 32'd1 : 32'd0);
            rd(8'h00, v); chk("R9 drain bit", v, (k < DR) ? 32'h1 : 32'h0);
            if (k < DR) tick();
        end

        // R9 restart during drain
        wr(8'h04, 32'h1);
        wr(8'h08, 32'h1);
        wr(8'h04, 32'h1);
        repeat (DR + 1) tick();
        chk("R9 restart keeps running", {31'b0, run}, 32'd1);

        // R10 soft reset kills run, R5 sets gate
        wr(8'h04, 32'h8000_0000);
        chk("R10 run off on srst", {31'b0, run}, 32'd0);
        rd(8'h00, v); chk("R5 srst sets gate", v, 32'hC000_0000);
        chk("R5 hold on srst", {31'b0, hold}, 32'd1);

        // Return to LIVE with plain writes
        wr(8'h00, 32'h0);
        repeat (ST) tick();
        wr(8'h00, 32'h0);
        repeat (ST) tick();
        rd(8'h00, v); chk("R6 R7 plain-write sequence", v, 32'h0);
        chk("R7 gate released", {31'b0, gate}, 32'd0);

        // R1 R2 R3 control misc bits
        wr(8'h00, 32'h0000_00F0);
        rd(8'h00, v); chk("R1 ctrl plain", v, 32'h0000_00F0);
        wr(8'h04, 32'h0000_0F00);
        rd(8'h08, v); chk("R2 ctrl set", v, 32'h0000_0FF0);
        wr(8'h08, 32'h0000_0030);
        rd(8'h0C, v); chk("R3 ctrl clear", v, 32'h0000_0FC0);
        ctrl_exp = 32'h0000_0FC0;

        // R1 R2 R3 sweep over configuration registers
        for (int r = 1; r < NR; r++) begin
            for (int k = 0; k < 6; k++) begin
                logic [DW-1:0] pat;
                int o;
                pat = (32'h9E37_79B9 * (k + 1)) ^ DW'(r << 8);
                o = k % 3;
                wr(AW'(r*16 + o*4), pat);
                if (o == 0)      model[r] = pat;
                else if (o == 1) model[r] = model[r] | pat;
                else             model[r] = model[r] & ~pat;
                for (int a = 0; a < 4; a++) begin
                    rd(AW'(r*16 + a*4), v);
                    chk((o == 0) ? "R1 plain" : (o == 1) ? "R2 set" : "R3 clear", v, model[r]);
                end
                chk("R1 cfg_o slice", cfg[(r-1)*DW +: DW], model[r]);
            end
        end

        // R4 ordering, read-only slot, out-of-range slot
        wr(8'h14, 32'h0000_0001);
        wr(8'h18, 32'h0000_0001);
        model[1] = (model[1] | 32'h1) & ~32'h1;
        rd(8'h10, v); chk("R4 set then clear", v, model[1]);
        wr(8'h18, 32'h0000_0002);
        wr(8'h14, 32'h0000_0002);
        model[1] = model[1] | 32'h2;
        rd(8'h10, v); chk("R4 clear then set", v, model[1]);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R4 read-only slot ignored", v, model[1]);
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, v); chk("R4 out-of-range reads 0", v, 32'h0);
        for (int r = 1; r < NR; r++) begin
            rd(AW'(r*16), v); chk("R4 out-of-range write ignored", v, model[r]);
        end
        rd(8'h00, v); chk("R4 ctrl untouched", v, ctrl_exp);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule